// File: doc/BRIEF.md
# DLL Start-up Sequencer for a DDR SRAM Interface

This block sits on the controller side of a double-data-rate SRAM whose output timing comes from an internal delay-locked loop. After reset, and again after a frequency change or a clock interruption, it brings the memory to a usable state. It drives the memory's DLL-disable pin (active low) and gates the memory clocks. During a clock stop it holds the output clock low. It keeps the command path parked on NOP until the memory's lock or recovery interval has elapsed, and then it raises `ready` to the rest of the controller.

Three start-up flavours are selected by `mode_i`:
- **Bypass.** The DLL stays off. This mode is required below roughly 119 MHz, where the DLL cannot operate.
- **Pin-controlled.** The disable pin is held low while the clocks run, and is then raised.
- **Clock-controlled.** The disable pin stays high, and the clocks are stopped for at least 30 ns with the output clock low.

Every flavour ends with a fixed run of NOP cycles. The stop interval is given in reference-clock cycles. It is computed from the clock period so that it always covers the required minimum time.

Top module: `dllinit_seq`

## Requirements
- R1: While `rst_n` is low, the outputs hold these values: `clock_enable_o`=0, `c_force_low_o`=0, `doff_n_o`=0, `force_nop_o`=1, `ready_o`=0.
- R2: Mode code 0 (bypass) and reserved code 3 behave the same. Counting from the first clock edge with reset released, the clocks run with `doff_n_o`=0 for exactly NOP_CYCLES (default 1024) non-ready cycles, and then `ready_o` rises. `doff_n_o` stays low while ready.
- R3: Mode code 1 (pin-controlled) starts with STOP_CYCLES cycles in which the clocks run and `doff_n_o`=0. Then `doff_n_o` goes to 1 and NOP_CYCLES NOP cycles follow before `ready_o` rises.
- R4: Mode code 2 (clock-controlled) starts with STOP_CYCLES cycles in which `clock_enable_o`=0 and `c_force_low_o`=1. `doff_n_o` stays 1 throughout. The clocks are then enabled for NOP_CYCLES NOP cycles before `ready_o` rises.
- R5: STOP_CYCLES equals the ceiling of STOP_MIN_PS / CLK_PERIOD_PS. With a 4 ns period and 30 ns minimum, this gives 8 cycles.
- R6: While ready, `force_nop_o` is 0, and `ready_o` stays high until a request is sampled. `ready_o` is low in the cycle after a request is sampled.
- R7: A `freq_chg_i` sampled while ready repeats the full start-up sequence of R2, R3 or R4.
- R8: A `restart_i` sampled while ready starts a recovery of NOP_CYCLES NOP cycles. During this recovery the clocks run, `doff_n_o` keeps its value and no clock stop occurs.
- R9: When `freq_chg_i` and `restart_i` are sampled together while ready, the frequency change is served.
- R10: `freq_chg_i` and `restart_i` have no effect while not ready. `mode_i` is sampled only at the first edge after reset and when a frequency change is accepted.
- R11: `force_nop_o` is 1 in every non-ready cycle. `ready_o` rises only when a complete NOP interval ends. The clocks are re-enabled only into a NOP interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Start-up mode: 0 bypass, 1 pin-controlled, 2 clock-controlled, 3 treated as bypass |
| freq_chg_i | input | 1 | Frequency-change request (re-lock) |
| restart_i | input | 1 | Clock-restart request (NOP recovery) |
| clock_enable_o | output | 1 | Enables the memory's input and output clocks |
| c_force_low_o | output | 1 | Holds the output clock low during a clock stop |
| doff_n_o | output | 1 | Memory DLL-disable pin, low disables the DLL |
| force_nop_o | output | 1 | Forces the command interface to NOP |
| ready_o | output | 1 | Memory usable for reads and writes |

## Verification
Several properties are checked by assertions on every cycle:
- the disable pin never moves during a NOP interval;
- bypass mode never presents a high disable pin while ready;
- any clock shutdown is accompanied by the output clock being forced low;
- a clock re-enable lands in a NOP interval;
- `ready` only rises at the end of a completed count;
- `ready` falls the cycle after an accepted request.

Other properties need the bench's scenarios, because they are lengths and choices rather than cycle-local relations:
- the exact lengths of the stop and NOP phases per mode;
- the re-sampling of the mode on a frequency change;
- the priority between simultaneous requests;
- that requests raised mid-sequence leave the timing unchanged.

// File: rtl/dllinit_pkg.sv
package dllinit_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS  = 2'd0,
        MODE_PIN     = 2'd1,
        MODE_CLKSTOP = 2'd2,
        MODE_RSVD    = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PRELOCK = 3'd1,
        ST_STOP    = 3'd2,
        ST_NOP     = 3'd3,
        ST_READY   = 3'd4
    } state_e;

    typedef struct packed {
        state_e st;
        mode_e  mode;
    } seq_t;

    function automatic logic dll_used(input mode_e m);
        return (m == MODE_PIN) || (m == MODE_CLKSTOP);
    endfunction

endpackage

// File: rtl/dllinit_timer.sv
module dllinit_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load_i) begin
            count_d = load_val_i;
        end else if (count_q != '0) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign zero_o = (count_q == '0);

endmodule

// File: rtl/dllinit_fsm.sv
module dllinit_fsm
    import dllinit_pkg::*;
#(
    parameter int NOP_CYCLES  = 1024,
    parameter int STOP_CYCLES = 8,
    parameter int CNT_W       = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             freq_chg_i,
    input  logic             restart_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             clock_enable_o,
    output logic             c_force_low_o,
    output logic             doff_n_o,
    output logic             force_nop_o,
    output logic             ready_o
);

    localparam logic [CNT_W-1:0] NOP_LOAD  = CNT_W'(NOP_CYCLES - 1);
    localparam logic [CNT_W-1:0] STOP_LOAD = CNT_W'(STOP_CYCLES - 1);

    seq_t  cur_q, nxt_d;
    logic  launch;
    mode_e launch_mode;

    always_comb begin
        nxt_d       = cur_q;
        tmr_load_o  = 1'b0;
        tmr_val_o   = '0;
        launch      = 1'b0;
        launch_mode = mode_e'(mode_i);

        case (cur_q.st)
            ST_IDLE: begin
                launch = 1'b1;
            end
            ST_PRELOCK, ST_STOP: begin
                if (tmr_zero_i) begin
                    nxt_d.st   = ST_NOP;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = NOP_LOAD;
                end
            end
            ST_NOP: begin
                if (tmr_zero_i) begin
                    nxt_d.st = ST_READY;
                end
            end
            ST_READY: begin
                if (freq_chg_i) begin
                    launch = 1'b1;
                end else if (restart_i) begin
                    nxt_d.st   = ST_NOP;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = NOP_LOAD;
                end
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase

        if (launch) begin
            nxt_d.mode = launch_mode;
            tmr_load_o = 1'b1;
            case (launch_mode)
                MODE_PIN: begin
                    nxt_d.st  = ST_PRELOCK;
                    tmr_val_o = STOP_LOAD;
                end
                MODE_CLKSTOP: begin
                    nxt_d.st  = ST_STOP;
                    tmr_val_o = STOP_LOAD;
                end
                default: begin
                    nxt_d.st  = ST_NOP;
                    tmr_val_o = NOP_LOAD;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, mode: MODE_BYPASS};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        clock_enable_o = 1'b1;
        c_force_low_o  = 1'b0;
        doff_n_o       = dll_used(cur_q.mode);
        force_nop_o    = 1'b1;
        ready_o        = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                clock_enable_o = 1'b0;
                doff_n_o       = 1'b0;
            end
            ST_PRELOCK: begin
                doff_n_o = 1'b0;
            end
            ST_STOP: begin
                clock_enable_o = 1'b0;
                c_force_low_o  = 1'b1;
                doff_n_o       = 1'b1;
            end
            ST_READY: begin
                force_nop_o = 1'b0;
                ready_o     = 1'b1;
            end
            default: begin
            end
        endcase
    end

    AST_NOP_DOFF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_NOP) && $past(cur_q.st == ST_NOP) |-> $stable(doff_n_o)); // R8

    AST_BYPASS_DOFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && !dll_used(cur_q.mode) |-> !doff_n_o); // R2

    AST_CLK_OFF_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clock_enable_o) && $past(cur_q.st != ST_IDLE) |-> c_force_low_o); // R4

    AST_CLK_ON_INTO_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clock_enable_o) |-> force_nop_o); // R11

    AST_READY_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(tmr_zero_i) && $past(cur_q.st == ST_NOP)); // R11

    AST_REINIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && (freq_chg_i || restart_i) |=> !ready_o); // R6

endmodule

// File: rtl/dllinit_seq.sv
module dllinit_seq #(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int STOP_MIN_PS   = 30000,
    parameter int NOP_CYCLES    = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       freq_chg_i,
    input  logic       restart_i,
    output logic       clock_enable_o,
    output logic       c_force_low_o,
    output logic       doff_n_o,
    output logic       force_nop_o,
    output logic       ready_o
);

    localparam int STOP_RAW    = (STOP_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int STOP_CYCLES = (STOP_RAW < 1) ? 1 : STOP_RAW;
    localparam int MAX_CYCLES  = (NOP_CYCLES > STOP_CYCLES) ? NOP_CYCLES : STOP_CYCLES;
    localparam int CNT_W       = $clog2(MAX_CYCLES) + 1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    dllinit_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    dllinit_fsm #(
        .NOP_CYCLES (NOP_CYCLES),
        .STOP_CYCLES(STOP_CYCLES),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode_i),
        .freq_chg_i     (freq_chg_i),
        .restart_i      (restart_i),
        .tmr_zero_i     (tmr_zero),
        .tmr_load_o     (tmr_load),
        .tmr_val_o      (tmr_val),
        .clock_enable_o (clock_enable_o),
        .c_force_low_o  (c_force_low_o),
        .doff_n_o       (doff_n_o),
        .force_nop_o    (force_nop_o),
        .ready_o        (ready_o)
    );

endmodule

// File: tb/dllinit_seq_bench.sv
module dllinit_seq_bench;

    localparam int PERIOD_PS = 4000;
    localparam int NOPN      = 1024;
    localparam int STOPN     = (30000 + PERIOD_PS - 1) / PERIOD_PS;

    // columns: mode code, non-ready cycles, stop cycles, doff-low cycles, doff when ready
    localparam int VEC [4][5] = '{
        '{0, NOPN,         0,     NOPN,  0},
        '{1, STOPN + NOPN, 0,     STOPN, 1},
        '{2, STOPN + NOPN, STOPN, 0,     1},
        '{3, NOPN,         0,     NOPN,  0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       freq_chg_i = 1'b0;
    logic       restart_i = 1'b0;
    logic       clock_enable_o, c_force_low_o, doff_n_o, force_nop_o, ready_o;

    int n_pass = 0;
    int n_tot  = 0;

    always #2 clk = ~clk;

    dllinit_seq #(
        .CLK_PERIOD_PS(PERIOD_PS),
        .STOP_MIN_PS  (30000),
        .NOP_CYCLES   (NOPN)
    ) u_dllinit_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode_i),
        .freq_chg_i     (freq_chg_i),
        .restart_i      (restart_i),
        .clock_enable_o (clock_enable_o),
        .c_force_low_o  (c_force_low_o),
        .doff_n_o       (doff_n_o),
        .force_nop_o    (force_nop_o),
        .ready_o        (ready_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tot++;
        if (act == exp) n_pass++;
        else $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n  = 1'b0;
        mode_i = m;
        repeat (3) @(negedge clk);
        chk("R1", "reset outputs {ce,cfl,doff,nop,rdy}",
            int'({clock_enable_o, c_force_low_o, doff_n_o, force_nop_o, ready_o}), 5'b00010);
        rst_n = 1'b1;
    endtask

    // Counts non-ready cycles after the next rising edge; requests are cleared after it.
    task automatic run_init(input int inject_at, output int tot, output int stp,
                            output int coff, output int dlow, output int nopbad,
                            output int fdoff);
        tot = 0; stp = 0; coff = 0; dlow = 0; nopbad = 0; fdoff = -1;
        for (int k = 0; k < 4000; k++) begin
            @(posedge clk);
            @(negedge clk);
            freq_chg_i = 1'b0;
            restart_i  = 1'b0;
            if (ready_o) begin
                fdoff = int'(doff_n_o);
                break;
            end
            tot++;
            if (!clock_enable_o) coff++;
            if (!clock_enable_o && c_force_low_o) stp++;
            if (!doff_n_o) dlow++;
            if (!force_nop_o) nopbad++;
            if (k == inject_at) begin
                freq_chg_i = 1'b1;
                restart_i  = 1'b1;
            end
        end
    endtask

    initial begin
        int tot, stp, coff, dlow, nopbad, fdoff;
        string tg;

        // R2 R3 R4 R5: table of start-up modes
        for (int r = 0; r < 4; r++) begin
            tg = (VEC[r][0] == 1) ? "R3" : (VEC[r][0] == 2) ? "R4" : "R2";
            do_reset(VEC[r][0][1:0]);
            run_init(-1, tot, stp, coff, dlow, nopbad, fdoff);
            chk(tg, "non-ready cycles", tot, VEC[r][1]);
            chk("R5", "clock-stop cycles", stp, VEC[r][2]);
            chk(tg, "clock-off cycles", coff, VEC[r][2]);
            chk(tg, "doff-low cycles", dlow, VEC[r][3]);
            chk(tg, "doff when ready", fdoff, VEC[r][4]);
            chk("R11", "force_nop low while not ready", nopbad, 0);
        end

        // R6: ready holds with no request, force_nop low
        repeat (30) @(negedge clk);
        chk("R6", "ready holds", int'(ready_o), 1);
        chk("R6", "force_nop while ready", int'(force_nop_o), 0);

        // R7: frequency change in pin mode repeats pin sequence
        do_reset(2'd1);
        run_init(-1, tot, stp, coff, dlow, nopbad, fdoff);
        freq_chg_i = 1'b1;
        run_init(-1, tot, stp, coff, dlow, nopbad, fdoff);
        chk("R7", "pin re-lock non-ready cycles", tot, STOPN + NOPN);
        chk("R7", "pin re-lock doff-low cycles", dlow, STOPN);
        chk("R7", "pin re-lock doff when ready", fdoff, 1);

        // R9: both requests together -> frequency change served
        freq_chg_i = 1'b1;
        restart_i  = 1'b1;
        run_init(-1, tot, stp, coff, dlow, nopbad, fdoff);
        chk("R9", "priority non-ready cycles", tot, STOPN + NOPN);
        chk("R9", "priority doff-low cycles", dlow, STOPN);

        // R8: restart in clock-controlled mode -> NOP only, no stop
        do_reset(2'd2);
        run_init(-1, tot, stp, coff, dlow, nopbad, fdoff);
        restart_i = 1'b1;
        run_init(-1, tot, stp, coff, dlow, nopbad, fdoff);
        chk("R8", "restart non-ready cycles", tot, NOPN);
        chk("R8", "restart clock-off cycles", coff, 0);
        chk("R8", "restart doff-low cycles", dlow, 0);

        // R10: mode_i change without a request has no effect
        mode_i = 2'd0;
        repeat (20) @(negedge clk);
        chk("R10", "doff after unrequested mode change", int'(doff_n_o), 1);
        chk("R10", "ready after unrequested mode change", int'(ready_o), 1);

        // R7: frequency change re-samples mode (clock mode -> bypass)
        freq_chg_i = 1'b1;
        run_init(-1, tot, stp, coff, dlow, nopbad, fdoff);
        chk("R7", "switch to bypass non-ready cycles", tot, NOPN);
        chk("R7", "switch to bypass doff-low cycles", dlow, NOPN);
        chk("R7", "switch to bypass doff when ready", fdoff, 0);

        // R10: requests during start-up are ignored
        do_reset(2'd0);
        run_init(100, tot, stp, coff, dlow, nopbad, fdoff);
        chk("R10", "requests mid-sequence non-ready cycles", tot, NOPN);
        do_reset(2'd2);
        run_init(3, tot, stp, coff, dlow, nopbad, fdoff);
        chk("R10", "request during clock stop non-ready cycles", tot, STOPN + NOPN);
        chk("R10", "request during clock stop stop cycles", stp, STOPN);

        $display("%0d/%0d checks passed", n_pass, n_tot);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tot++;
        $display("FAIL watchdog R11: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_pass, n_tot);
        $finish;
    end

endmodule